// File: doc/BRIEF.md
# Ethernet Receive Ping-Pong Buffer with Destination Filter

This block is the receive half of a small Ethernet MAC. A decoded byte stream arrives with start-of-frame and end-of-frame markers on a valid strobe. The first six bytes are the destination address, which decides whether the frame is taken. A frame is taken when the top bit (bit 7) of its first destination byte is set, or when all six destination bytes match the configured station address. Bytes of the frame are packed into 32-bit words of one of two frame stores. The store is picked by an internal index. The final accept, drop or discard decision is made on the end-of-frame byte.

When a frame is kept, the store's full flag and stored byte count are set. If enabled, a one-cycle interrupt pulse follows. In alternating mode the index then moves to the other store. A full store blocks new frames until software clears its flag through the control register. Frames refused because the store is full, or because they are too long, advance a saturating lost-frame counter. Frames refused by the address filter vanish silently. Software reads the stores and the registers over a simple 32-bit register bus with a one-cycle read latency.

Top module: `eth_rx_pingpong`

## Requirements
- R1: A frame is kept only if bit 7 of destination byte 0 is 1, or if destination bytes 0..5 equal station_mac_i[47:40], [39:32], ..., [7:0] in that order. A frame that fails this test, or that has fewer than six bytes, changes no full flag, no counter and no interrupt.
- R2: If the active store's full flag is 1 when the frame starts, a frame that passes the filter is not written to that store and the lost counter increases by one.
- R3: A frame of 2020 bytes or more that passes the filter is dropped: full flag unchanged, lost counter plus one. A 2019-byte frame is stored.
- R4: A kept frame sets bit 0 (full) of its store's control register, and sets that store's length register to the frame's byte count.
- R5: irq_o is high for exactly one cycle, the cycle after the end-of-frame byte of a kept frame. This happens only when bit 3 (interrupt enable) of that store's control register is 1 and irq_gen_i is 1.
- R6: Reset selects store 0. With pp_mode_i=1 the index toggles after each kept frame. With pp_mode_i=0 it is held at 0.
- R7: Register map: store 0 data at 0x1000, store 1 data at 0x1800, control at 0x17FC / 0x1FFC, length at 0x17F8 / 0x1FF8, lost counter at 0x17F4 (also 0x1FF4). Read data appears on bus_rdata_o the cycle after bus_rd_i. Other addresses read 0.
- R8: Frame byte k is held in word k/4 of the store, in bits [8*(k mod 4)+7 : 8*(k mod 4)].
- R9: A bus write to a control register loads full from bus_wdata_i[0] and interrupt enable from bus_wdata_i[3]. Clearing full lets the next frame be stored there.
- R10: The lost counter holds at 2^LOST_W-1 (255 by default) once reached.
- R11: After reset both control registers, both length registers, the lost counter and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_mac_i | input | 48 | Station address, first wire byte in [47:40] |
| pp_mode_i | input | 1 | 1 = alternate between the two stores |
| irq_gen_i | input | 1 | Global interrupt enable |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | Marks the first byte of a frame |
| rx_eof_i | input | 1 | Marks the last byte of a frame |
| rx_data_i | input | 8 | Frame byte |
| bus_addr_i | input | 13 | Byte address |
| bus_rd_i | input | 1 | Read strobe |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after bus_rd_i |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The hardest state to reach from the ports is the lost counter at saturation while a store stays full. It takes hundreds of refused frames. The bench leaves store 0 full with alternation off and streams minimum-length matching frames until the counter must have passed its ceiling. The oversize boundary is also costly, since it needs full-length frames of 2019 and 2020 bytes. The last stored byte lane is read back to confirm nothing ran past the store.

// File: rtl/eth_rxpp_pkg.sv
package eth_rxpp_pkg;

  localparam int NUM_STORES = 2;

  localparam logic [10:0] OFS_LOST = 11'h7F4;
  localparam logic [10:0] OFS_LEN  = 11'h7F8;
  localparam logic [10:0] OFS_CTRL = 11'h7FC;

  typedef enum logic [2:0] {
    V_NONE,
    V_REJECT,
    V_LOST_FULL,
    V_LOST_BIG,
    V_STORE
  } verdict_e;

  // Destination byte k (0 = first on the wire) of a station address.
  function automatic logic [7:0] mac_byte(input logic [47:0] mac, input logic [2:0] k);
    logic [47:0] t;
    t = mac >> (6'd40 - {k, 3'b000});
    return t[7:0];
  endfunction

  function automatic logic [31:0] ctrl_word(input logic ie, input logic full);
    logic [31:0] w;
    w = '0;
    w[3] = ie;
    w[0] = full;
    return w;
  endfunction

endpackage

// File: rtl/eth_rxpp_addr_filter.sv
module eth_rxpp_addr_filter
  import eth_rxpp_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       data,
  input  logic [47:0]      station_mac,
  output logic             addr_ok
);
  localparam logic [POS_W-1:0] DA_LAST = POS_W'(5);
  localparam logic [POS_W-1:0] DA_LEN  = POS_W'(6);

  logic grp_q, match_q;
  logic cur_grp, cur_match, base;

  always_comb begin
    cur_grp = (pos == '0) ? data[7] : grp_q;
    base    = (pos == '0) ? 1'b1 : match_q;
    if (pos < DA_LEN) cur_match = base & (data == mac_byte(station_mac, pos[2:0]));
    else              cur_match = match_q;
    addr_ok = (pos >= DA_LAST) & (cur_grp | cur_match);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q   <= 1'b0;
      match_q <= 1'b0;
    end else if (byte_en) begin
      grp_q   <= cur_grp;
      match_q <= cur_match;
    end
  end
endmodule

// File: rtl/eth_rxpp_frame_ctl.sv
module eth_rxpp_frame_ctl
  import eth_rxpp_pkg::*;
#(
  parameter int BUF_BYTES = 2020,
  parameter int POS_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             active_full,
  input  logic             addr_ok,
  output logic             byte_en,
  output logic [POS_W-1:0] pos,
  output logic             wr_en,
  output logic [POS_W-1:0] frame_len,
  output verdict_e         verdict
);
  localparam logic [POS_W-1:0] CAP      = POS_W'(BUF_BYTES);
  localparam logic [POS_W-1:0] BIG_LAST = POS_W'(BUF_BYTES - 1);

  logic             in_frame_q, blocked_q;
  logic [POS_W-1:0] cnt_q;
  logic             cur_blocked, last, oversize;

  always_comb begin
    byte_en     = rx_valid & (rx_sof | in_frame_q);
    pos         = rx_sof ? '0 : cnt_q;
    cur_blocked = rx_sof ? active_full : blocked_q;
    wr_en       = byte_en & ~cur_blocked & (pos < CAP);
    last        = byte_en & rx_eof;
    oversize    = (pos >= BIG_LAST);
    frame_len   = pos + POS_W'(1);
    if (!last)             verdict = V_NONE;
    else if (!addr_ok)     verdict = V_REJECT;
    else if (cur_blocked)  verdict = V_LOST_FULL;
    else if (oversize)     verdict = V_LOST_BIG;
    else                   verdict = V_STORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      blocked_q  <= 1'b0;
      cnt_q      <= '0;
    end else if (byte_en) begin
      in_frame_q <= ~rx_eof;
      blocked_q  <= cur_blocked;
      cnt_q      <= (pos == CAP) ? pos : pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/eth_rxpp_buf_mem.sv
module eth_rxpp_buf_mem
  import eth_rxpp_pkg::*;
#(
  parameter int WORDS  = 505,
  parameter int POS_W  = 11,
  parameter int WIDX_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       data,
  input  logic             rd_sel,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [NUM_STORES-1:0][31:0] bank_rd;
  logic [WIDX_W-1:0] wr_idx;
  logic [1:0]        lane;

  assign wr_idx = WIDX_W'(pos >> 2);
  assign lane   = pos[1:0];

  for (genvar b = 0; b < NUM_STORES; b++) begin : g_store
    logic [31:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 1'(b)))
        mem[wr_idx][{lane, 3'b000} +: 8] <= data;
    end
    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_word = bank_rd[rd_sel];
endmodule

// File: rtl/eth_rxpp_ctrl_regs.sv
module eth_rxpp_ctrl_regs
  import eth_rxpp_pkg::*;
#(
  parameter int POS_W  = 11,
  parameter int LOST_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pp_mode,
  input  logic                              irq_gen,
  input  verdict_e                          verdict,
  input  logic [POS_W-1:0]                  frame_len,
  input  logic                              sw_wr,
  input  logic                              sw_sel,
  input  logic                              sw_full,
  input  logic                              sw_ie,
  output logic                              active_q,
  output logic [NUM_STORES-1:0]             full_q,
  output logic [NUM_STORES-1:0]             ie_q,
  output logic [NUM_STORES-1:0][POS_W-1:0]  len_q,
  output logic [LOST_W-1:0]                 lost_q,
  output logic                              irq_q
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= '0;
      ie_q     <= '0;
      len_q    <= '0;
      lost_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (sw_wr) begin
        full_q[sw_sel] <= sw_full;
        ie_q[sw_sel]   <= sw_ie;
      end
      unique case (verdict)
        V_STORE: begin
          full_q[active_q] <= 1'b1;
          len_q[active_q]  <= frame_len;
          irq_q            <= ie_q[active_q] & irq_gen;
        end
        V_LOST_FULL, V_LOST_BIG: begin
          if (lost_q != LOST_MAX) lost_q <= lost_q + LOST_W'(1);
        end
        default: ;
      endcase
      if (!pp_mode)                active_q <= 1'b0;
      else if (verdict == V_STORE) active_q <= ~active_q;
    end
  end
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
  import eth_rxpp_pkg::*;
#(
  parameter int BUF_BYTES = 2020,
  parameter int LOST_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] station_mac_i,
  input  logic        pp_mode_i,
  input  logic        irq_gen_i,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [7:0]  rx_data_i,
  input  logic [12:0] bus_addr_i,
  input  logic        bus_rd_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  localparam int POS_W  = $clog2(BUF_BYTES + 1);
  localparam int WORDS  = (BUF_BYTES + 3) / 4;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  // Named internal events, used by the bound checker.
  logic                             byte_en, wr_en, addr_ok;
  logic [POS_W-1:0]                 pos, frame_len;
  verdict_e                         verdict;
  logic                             active_q;
  logic [NUM_STORES-1:0]            full_q, ie_q;
  logic [NUM_STORES-1:0][POS_W-1:0] len_q;
  logic [LOST_W-1:0]                lost_q;
  logic                             ctrl_wr;

  logic        rx_space, half;
  logic [10:0] ofs;
  logic [31:0] store_word, rd_mux;
  logic        unused_wdata;

  assign rx_space     = bus_addr_i[12];
  assign half         = bus_addr_i[11];
  assign ofs          = bus_addr_i[10:0];
  assign ctrl_wr      = bus_we_i & rx_space & (ofs == OFS_CTRL);
  assign unused_wdata = ^{bus_wdata_i[31:4], bus_wdata_i[2:1]};

  eth_rxpp_addr_filter #(.POS_W(POS_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .pos(pos), .data(rx_data_i),
    .station_mac(station_mac_i), .addr_ok(addr_ok)
  );

  eth_rxpp_frame_ctl #(.BUF_BYTES(BUF_BYTES), .POS_W(POS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid_i), .rx_sof(rx_sof_i),
    .rx_eof(rx_eof_i), .active_full(full_q[active_q]), .addr_ok(addr_ok),
    .byte_en(byte_en), .pos(pos), .wr_en(wr_en), .frame_len(frame_len),
    .verdict(verdict)
  );

  eth_rxpp_buf_mem #(.WORDS(WORDS), .POS_W(POS_W), .WIDX_W(WIDX_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_sel(active_q), .pos(pos), .data(rx_data_i),
    .rd_sel(half), .rd_idx(WIDX_W'(ofs >> 2)), .rd_word(store_word)
  );

  eth_rxpp_ctrl_regs #(.POS_W(POS_W), .LOST_W(LOST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pp_mode(pp_mode_i), .irq_gen(irq_gen_i),
    .verdict(verdict), .frame_len(frame_len), .sw_wr(ctrl_wr), .sw_sel(half),
    .sw_full(bus_wdata_i[0]), .sw_ie(bus_wdata_i[3]),
    .active_q(active_q), .full_q(full_q), .ie_q(ie_q), .len_q(len_q),
    .lost_q(lost_q), .irq_q(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rx_space) begin
      if (ofs == OFS_CTRL)              rd_mux = ctrl_word(ie_q[half], full_q[half]);
      else if (ofs == OFS_LEN)          rd_mux = 32'(len_q[half]);
      else if (ofs == OFS_LOST)         rd_mux = 32'(lost_q);
      else if (ofs < 11'(BUF_BYTES))    rd_mux = store_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/eth_rxpp_checks.sv
module eth_rxpp_checks
  import eth_rxpp_pkg::*;
#(
  parameter int LOST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pp_mode,
  input logic              irq_gen,
  input logic              irq,
  input verdict_e          verdict,
  input logic              active,
  input logic [1:0]        full,
  input logic [1:0]        ie,
  input logic [LOST_W-1:0] lost,
  input logic              ctrl_wr
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_REJECT && !ctrl_wr) |=> (full == $past(full)) && (lost == $past(lost)) && !irq);

  p_lost_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_LOST_FULL && lost != LOST_MAX) |=> lost == $past(lost) + LOST_W'(1));

  p_lost_big_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_LOST_BIG && !ctrl_wr && lost != LOST_MAX) |=>
      (lost == $past(lost) + LOST_W'(1)) && (full == $past(full)) && !irq);

  p_store_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_STORE) |=> full[$past(active)]);

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(verdict == V_STORE) && $past(irq_gen) && $past(ie[active]));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_pp_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_STORE && pp_mode) |=> active != $past(active));

  p_nopp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_mode |=> !active);

  p_lost_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lost == LOST_MAX) |=> lost == LOST_MAX);
endmodule

bind eth_rx_pingpong eth_rxpp_checks #(.LOST_W(LOST_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .pp_mode(pp_mode_i), .irq_gen(irq_gen_i), .irq(irq_o),
  .verdict(verdict), .active(active_q), .full(full_q), .ie(ie_q), .lost(lost_q),
  .ctrl_wr(ctrl_wr)
);

// File: tb/eth_rx_pingpong_tb_top.sv
module eth_rx_pingpong_tb_top;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pp_mode = 1'b0, irq_gen = 1'b1;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [12:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;

  int tests = 0, fails = 0, irq_seen = 0, exp_lost = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eth_rx_pingpong dut_i (
    .clk(clk), .rst_n(rst_n), .station_mac_i(MAC), .pp_mode_i(pp_mode),
    .irq_gen_i(irq_gen), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_data_i(rx_data), .bus_addr_i(bus_addr), .bus_rd_i(bus_rd), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  typedef struct packed {
    logic [2:0]  kind;
    logic [11:0] len;
    logic [7:0]  seed;
    logic        acc;
  } vec_t;

  // kind: 0 exact, 1 broadcast, 2 last byte differs, 3 only group bit, 4 first byte differs
  localparam vec_t VEC [8] = '{
    '{3'd0, 12'd64, 8'd1, 1'b1},
    '{3'd1, 12'd60, 8'd2, 1'b1},
    '{3'd2, 12'd64, 8'd3, 1'b0},
    '{3'd0, 12'd5,  8'd4, 1'b0},
    '{3'd1, 12'd5,  8'd5, 1'b0},
    '{3'd0, 12'd6,  8'd6, 1'b1},
    '{3'd3, 12'd20, 8'd7, 1'b1},
    '{3'd4, 12'd32, 8'd8, 1'b0}
  };

  function automatic logic [7:0] pay(int k, int seed);
    return 8'((k * 3 + seed * 17) & 255);
  endfunction

  function automatic logic [7:0] dbyte(int kind, int k);
    logic [7:0] m;
    m = 8'((MAC >> (8 * (5 - k))) & 48'hFF);
    case (kind)
      1: return 8'hFF;
      2: return (k == 5) ? (m ^ 8'h01) : m;
      3: return (k == 0) ? 8'h80 : 8'hAB;
      4: return (k == 0) ? (m ^ 8'h01) : m;
      default: return m;
    endcase
  endfunction

  function automatic logic [31:0] pword(int k0, int seed);
    return {pay(k0 + 3, seed), pay(k0 + 2, seed), pay(k0 + 1, seed), pay(k0, seed)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic send_frame(int kind, int len, int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == len - 1);
      rx_data = (k < 6) ? dbyte(kind, k) : pay(k, seed);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int i0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq after reset", 32'(irq), 0);
    bus_read(13'h17FC, d); chk("R11 ctrl0", d, 0);
    bus_read(13'h1FFC, d); chk("R11 ctrl1", d, 0);
    bus_read(13'h17F8, d); chk("R11 len0", d, 0);
    bus_read(13'h17F4, d); chk("R11 lost", d, 0);

    // Vector table: R1 filter, R4 status/length, R5 irq, R8 packing
    for (int v = 0; v < 8; v++) begin
      bus_write(13'h17FC, 32'h8);
      i0 = irq_seen;
      send_frame(int'(VEC[v].kind), int'(VEC[v].len), int'(VEC[v].seed));
      bus_read(13'h17FC, d); chk("R1 R4 ctrl0 after frame", d, VEC[v].acc ? 32'h9 : 32'h8);
      chk("R5 irq count", 32'(irq_seen - i0), VEC[v].acc ? 1 : 0);
      if (VEC[v].acc) begin
        bus_read(13'h17F8, d); chk("R4 length", d, 32'(VEC[v].len));
        if (VEC[v].len >= 12) begin
          bus_read(13'h1008, d); chk("R8 word 2", d, pword(8, int'(VEC[v].seed)));
        end
      end
    end
    bus_read(13'h17F4, d); chk("R1 no lost from filter", d, 0);

    // Alternating stores: R6, R2, R9
    bus_write(13'h17FC, 32'h8);
    bus_write(13'h1FFC, 32'h8);
    pp_mode = 1'b1;
    send_frame(0, 16, 10);
    bus_read(13'h17FC, d); chk("R6 first frame to store 0", d, 32'h9);
    bus_read(13'h1FFC, d); chk("R6 store 1 still free", d, 32'h8);
    send_frame(1, 24, 11);
    bus_read(13'h1FFC, d); chk("R6 second frame to store 1", d, 32'h9);
    bus_read(13'h1FF8, d); chk("R7 length 1", d, 24);
    bus_read(13'h1808, d); chk("R8 store 1 word 2", d, pword(8, 11));
    i0 = irq_seen;
    send_frame(0, 16, 12);
    exp_lost++;
    bus_read(13'h17F4, d); chk("R2 lost on full", d, 32'(exp_lost));
    bus_read(13'h1008, d); chk("R2 store 0 untouched", d, pword(8, 10));
    chk("R2 no irq", 32'(irq_seen - i0), 0);
    bus_write(13'h17FC, 32'h8);
    bus_read(13'h17FC, d); chk("R9 release", d, 32'h8);
    send_frame(0, 20, 13);
    bus_read(13'h17FC, d); chk("R9 stored after release", d, 32'h9);
    bus_read(13'h17F8, d); chk("R4 length 20", d, 20);
    bus_read(13'h100C, d); chk("R8 word 3", d, pword(12, 13));
    send_frame(0, 16, 14);
    exp_lost++;
    bus_read(13'h1FF4, d); chk("R2 R7 lost via alias", d, 32'(exp_lost));
    bus_write(13'h1FFC, 32'h1);
    bus_read(13'h1FFC, d); chk("R9 software set full", d, 32'h1);

    // Oversize boundary: R3, R6 index held at 0
    pp_mode = 1'b0;
    bus_write(13'h17FC, 32'h8);
    bus_write(13'h1FFC, 32'h0);
    i0 = irq_seen;
    send_frame(0, 2020, 20);
    exp_lost++;
    bus_read(13'h17FC, d); chk("R3 2020 not stored", d, 32'h8);
    bus_read(13'h17F4, d); chk("R3 lost on oversize", d, 32'(exp_lost));
    chk("R3 no irq", 32'(irq_seen - i0), 0);
    send_frame(0, 2019, 21);
    bus_read(13'h17FC, d); chk("R3 2019 stored", d, 32'h9);
    bus_read(13'h17F8, d); chk("R3 length 2019", d, 2019);
    bus_read(13'h17E0, d); chk("R8 last byte lane", d & 32'h00FF_FFFF,
                               {8'h00, pay(2018, 21), pay(2017, 21), pay(2016, 21)});

    // Interrupt gating: R5, R6
    irq_gen = 1'b0;
    bus_write(13'h17FC, 32'h8);
    i0 = irq_seen;
    send_frame(0, 8, 30);
    chk("R5 global gate off", 32'(irq_seen - i0), 0);
    irq_gen = 1'b1;
    bus_write(13'h17FC, 32'h0);
    i0 = irq_seen;
    send_frame(0, 8, 31);
    chk("R5 store enable off", 32'(irq_seen - i0), 0);
    bus_read(13'h17FC, d); chk("R5 stored without irq", d, 32'h1);
    bus_write(13'h17FC, 32'h8);
    i0 = irq_seen;
    send_frame(1, 8, 32);
    chk("R5 both enables", 32'(irq_seen - i0), 1);
    bus_read(13'h1FFC, d); chk("R6 store 1 unused with alternation off", d, 0);

    // Saturation: R10 (store 0 is full now)
    for (int n = 0; n < 260; n++) send_frame(0, 6, n);
    exp_lost = (exp_lost + 260 > 255) ? 255 : exp_lost + 260;
    bus_read(13'h17F4, d); chk("R10 lost saturates", d, 32'(exp_lost));

    // R7 unmapped
    bus_read(13'h0100, d); chk("R7 low space reads 0", d, 0);
    bus_read(13'h17F0, d); chk("R7 hole reads 0", d, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule